// File: doc/BRIEF.md
# Shared-Multiplier Beamforming Arithmetic Unit

This unit is the arithmetic core of a data-driven processing element in a beamforming chain. It has one array of four signed multipliers. An opcode picks one of three operations on that array: a four-tap FIR step, a complex product, or a radix-2 FFT butterfly. Every operation finishes in one firing. Nothing sequences the unit. An operation fires in the cycle where its opcode token, every operand token that opcode needs, and a ready consumer are all present. In that same cycle the unit pulls the tokens it used and loads its result register.

The unit keeps no filter memory inside the datapath. FIR history lives in a separate state store with four three-sample histories, chosen by a 2-bit state index. In the cycle a FIR step fires, the store is read and the shifted history is written back. Several independent filters can therefore share one unit by interleaving their samples. All samples are signed Q1.15. Each product sum is rounded to nearest, with ties going up, and then clipped to 16 bits.

Top module: `fbf_alu`

## Requirements
- R1: After reset the result valid is low and all four filter histories are zero, so the first FIR step on any index returns round(c0·x).
- R2: Opcode codes are 0 FIR, 1 complex multiply, 2 butterfly and 3 no-op. FIR takes sample x = x_re and coefficients c0 = y_re, c1 = y_im, c2 = w_re, c3 = w_im. Complex multiply takes a = x and b = w. The butterfly takes x, y and twiddle w.
- R3: Complex multiply returns r0 = (ar·br − ai·bi) + j(ar·bi + ai·br). Each part is rounded by adding 2^14 and shifting right arithmetically by 15, then clipped. r1 is zero.
- R4: The butterfly computes t = w·y with R3 rounding, then returns r0 = x + t and r1 = x − t. Each part is clipped to 16 bits.
- R5: A FIR step returns r0_re = c0·x[n] + c1·x[n−1] + c2·x[n−2] + c3·x[n−3], rounded once as in R3. r0_im and r1 are zero. The selected history then becomes x[n], x[n−1], x[n−2].
- R6: Each of the four state indices keeps its own history. A FIR step on one index leaves the other three unchanged.
- R7: An operation fires only in a cycle where the opcode token, each operand token its opcode needs, and res_rdy_i are all high. The ready of each channel consumed is high in exactly that cycle.
- R8: A complex multiply does not consume the y channel. A no-op consumes only the opcode token.
- R9: While res_rdy_i is low, no channel is consumed. A pending result stays valid with all four fields unchanged.
- R10: The result appears one cycle after firing. With every channel valid and res_rdy_i held high, the unit fires once per cycle.
- R11: A no-op produces a valid result with all four fields zero.
- R12: Results clip at the 16-bit limits. (−1)·(−1) gives +32767. A butterfly with x = y = w = 32767 on the real parts and zero imaginary parts gives r0_re = 32767 and r1_re = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld_i | input | 1 | Opcode token present |
| op_rdy_o | output | 1 | Opcode token consumed |
| op_code_i | input | 2 | Operation code (R2) |
| op_sidx_i | input | 2 | FIR state index |
| x_vld_i | input | 1 | x operand present |
| x_rdy_o | output | 1 | x operand consumed |
| x_re_i | input | 16 | x real part / FIR sample |
| x_im_i | input | 16 | x imaginary part |
| y_vld_i | input | 1 | y operand present |
| y_rdy_o | output | 1 | y operand consumed |
| y_re_i | input | 16 | y real part / c0 |
| y_im_i | input | 16 | y imaginary part / c1 |
| w_vld_i | input | 1 | w operand present |
| w_rdy_o | output | 1 | w operand consumed |
| w_re_i | input | 16 | w real part / c2 |
| w_im_i | input | 16 | w imaginary part / c3 |
| res_vld_o | output | 1 | Result valid |
| res_rdy_i | input | 1 | Consumer accepts result |
| r0_re_o | output | 16 | First result, real |
| r0_im_o | output | 16 | First result, imaginary |
| r1_re_o | output | 16 | Second result, real |
| r1_im_o | output | 16 | Second result, imaginary |

## Verification
The hardest case to reach is a FIR step that fires on a state index while other indices are partway through their own histories, and that step has been stalled by a busy consumer or a late operand. That is the only case where a history update at the wrong time, or to the wrong entry, shows up in later outputs. The stimulus first interleaves FIR samples across all four indices with every channel always valid. It then runs a long mixed sequence in which each channel's token arrives after a random delay and the consumer's ready toggles at random. A behavioural model of the four histories predicts every result and every ready, cycle by cycle. Fixed directed cases drive the clipping corners.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    localparam int DW   = 16;
    localparam int FRAC = DW - 1;
    localparam int NTAP = 4;
    localparam int HDEP = NTAP - 1;
    localparam int PW   = 2 * DW;
    localparam int AW   = PW + 2;

    typedef enum logic [1:0] {
        OP_FIR  = 2'd0,
        OP_CMUL = 2'd1,
        OP_BFLY = 2'd2,
        OP_NOP  = 2'd3
    } fbf_op_e;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic  vld;
        cplx_t r0;
        cplx_t r1;
    } fbf_out_t;

    localparam logic signed [AW:0] RHALF = (AW+1)'(2 ** (FRAC - 1));

    // Round half up at bit FRAC, then clip to DW bits.
    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [AW-1:0] acc);
        logic signed [AW:0] t;
        t = $signed({acc[AW-1], acc}) + RHALF;
        t = t >>> FRAC;
        if ((t[AW:DW-1] == '0) || (t[AW:DW-1] == '1))
            rnd_sat = t[DW-1:0];
        else
            rnd_sat = t[AW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    endfunction

    function automatic logic signed [DW-1:0] add_sat(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b,
                                                     input logic sub);
        logic signed [DW:0] s;
        if (sub)
            s = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
        else
            s = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
        if (s[DW] != s[DW-1])
            add_sat = s[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            add_sat = s[DW-1:0];
    endfunction
endpackage

// File: rtl/fbf_mul4.sv
module fbf_mul4 #(
    parameter int NMUL = 4,
    parameter int IW   = 16,
    localparam int OW  = 2 * IW
) (
    input  logic signed [IW-1:0] a_i [NMUL],
    input  logic signed [IW-1:0] b_i [NMUL],
    output logic signed [OW-1:0] p_o [NMUL]
);
    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        assign p_o[g] = OW'(a_i[g]) * OW'(b_i[g]);
    end
endmodule

// File: rtl/fbf_hist.sv
module fbf_hist #(
    parameter int NHIST = 4,
    parameter int DEPTH = 3,
    parameter int SW    = 16,
    localparam int XW   = $clog2(NHIST)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [XW-1:0]                   rd_idx_i,
    output logic [DEPTH-1:0][SW-1:0]        rd_hist_o,
    input  logic                            wr_en_i,
    input  logic [XW-1:0]                   wr_idx_i,
    input  logic [SW-1:0]                   wr_smp_i
);
    logic [NHIST-1:0][DEPTH-1:0][SW-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (wr_en_i) begin
            hist_d[wr_idx_i][0] = wr_smp_i;
            for (int k = 1; k < DEPTH; k++)
                hist_d[wr_idx_i][k] = hist_q[wr_idx_i][k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign rd_hist_o = hist_q[rd_idx_i];

    // R6: without a write, no history changes
    p_hist_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(hist_q));

    // R5: a write puts the new sample at the head of the chosen history
    p_hist_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> hist_q[$past(wr_idx_i)][0] == $past(wr_smp_i));
endmodule

// File: rtl/fbf_alu.sv
module fbf_alu
    import fbf_pkg::*;
#(
    parameter int NHIST = 4,
    localparam int SXW  = $clog2(NHIST)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_vld_i,
    output logic                 op_rdy_o,
    input  logic [1:0]           op_code_i,
    input  logic [SXW-1:0]       op_sidx_i,
    input  logic                 x_vld_i,
    output logic                 x_rdy_o,
    input  logic signed [DW-1:0] x_re_i,
    input  logic signed [DW-1:0] x_im_i,
    input  logic                 y_vld_i,
    output logic                 y_rdy_o,
    input  logic signed [DW-1:0] y_re_i,
    input  logic signed [DW-1:0] y_im_i,
    input  logic                 w_vld_i,
    output logic                 w_rdy_o,
    input  logic signed [DW-1:0] w_re_i,
    input  logic signed [DW-1:0] w_im_i,
    output logic                 res_vld_o,
    input  logic                 res_rdy_i,
    output logic signed [DW-1:0] r0_re_o,
    output logic signed [DW-1:0] r0_im_o,
    output logic signed [DW-1:0] r1_re_o,
    output logic signed [DW-1:0] r1_im_o
);
    fbf_op_e                  opc;
    logic                     need_x, need_y, need_w, fire;
    cplx_t                    src, tw;
    logic signed [DW-1:0]     ma [NTAP];
    logic signed [DW-1:0]     mb [NTAP];
    logic signed [PW-1:0]     mp [NTAP];
    logic [HDEP-1:0][DW-1:0]  hist_rd;
    logic signed [AW-1:0]     fir_acc, c_re, c_im;
    cplx_t                    tprod;
    fbf_out_t                 st_d, st_q;

    fbf_mul4 #(.NMUL(NTAP), .IW(DW)) u_mul (
        .a_i (ma),
        .b_i (mb),
        .p_o (mp)
    );

    fbf_hist #(.NHIST(NHIST), .DEPTH(HDEP), .SW(DW)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (op_sidx_i),
        .rd_hist_o (hist_rd),
        .wr_en_i   (fire && (opc == OP_FIR)),
        .wr_idx_i  (op_sidx_i),
        .wr_smp_i  (x_re_i)
    );

    always_comb begin
        opc    = fbf_op_e'(op_code_i);
        need_x = (opc != OP_NOP);
        need_y = (opc == OP_FIR) || (opc == OP_BFLY);
        need_w = (opc != OP_NOP);
        fire   = op_vld_i && (!need_x || x_vld_i) && (!need_y || y_vld_i)
                 && (!need_w || w_vld_i) && res_rdy_i;

        tw.re = w_re_i;
        tw.im = w_im_i;
        if (opc == OP_BFLY) begin
            src.re = y_re_i;
            src.im = y_im_i;
        end else begin
            src.re = x_re_i;
            src.im = x_im_i;
        end

        // Operand routing onto the shared multiplier array
        if (opc == OP_FIR) begin
            ma[0] = x_re_i;
            for (int k = 1; k < NTAP; k++) ma[k] = $signed(hist_rd[k-1]);
            mb[0] = y_re_i;
            mb[1] = y_im_i;
            mb[2] = w_re_i;
            mb[3] = w_im_i;
        end else begin
            ma[0] = src.re;  mb[0] = tw.re;
            ma[1] = src.im;  mb[1] = tw.im;
            ma[2] = src.re;  mb[2] = tw.im;
            ma[3] = src.im;  mb[3] = tw.re;
        end

        fir_acc = '0;
        for (int k = 0; k < NTAP; k++) fir_acc = fir_acc + AW'(mp[k]);
        c_re     = AW'(mp[0]) - AW'(mp[1]);
        c_im     = AW'(mp[2]) + AW'(mp[3]);
        tprod.re = rnd_sat(c_re);
        tprod.im = rnd_sat(c_im);

        st_d = st_q;
        if (fire) begin
            st_d.vld = 1'b1;
            st_d.r0  = '0;
            st_d.r1  = '0;
            unique case (opc)
                OP_FIR:  st_d.r0.re = rnd_sat(fir_acc);
                OP_CMUL: st_d.r0    = tprod;
                OP_BFLY: begin
                    st_d.r0.re = add_sat(x_re_i, tprod.re, 1'b0);
                    st_d.r0.im = add_sat(x_im_i, tprod.im, 1'b0);
                    st_d.r1.re = add_sat(x_re_i, tprod.re, 1'b1);
                    st_d.r1.im = add_sat(x_im_i, tprod.im, 1'b1);
                end
                default: ;
            endcase
        end else if (res_rdy_i) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_rdy_o  = fire;
    assign x_rdy_o   = fire && need_x;
    assign y_rdy_o   = fire && need_y;
    assign w_rdy_o   = fire && need_w;
    assign res_vld_o = st_q.vld;
    assign r0_re_o   = st_q.r0.re;
    assign r0_im_o   = st_q.r0.im;
    assign r1_re_o   = st_q.r1.re;
    assign r1_im_o   = st_q.r1.im;

    // R9: a stalled result stays put
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && !res_rdy_i) |=> (res_vld_o && $stable({r0_re_o, r0_im_o, r1_re_o, r1_im_o})));

    // R9: nothing is consumed while the consumer is busy
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_rdy_i |-> !(op_rdy_o || x_rdy_o || y_rdy_o || w_rdy_o));

    // R7: a real operation consumes only present tokens
    p_need_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rdy_o && op_code_i != 2'd3) |-> (op_vld_i && x_vld_i && w_vld_i));

    // R8: complex multiply leaves y alone
    p_cmul_y_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rdy_o && op_code_i == 2'd1) |-> !y_rdy_o);

    // R10: a firing yields a valid result next cycle
    p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_rdy_o |=> res_vld_o);
endmodule

// File: tb/fbf_alu_test.sv
`timescale 1ns/1ps
module fbf_alu_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        op_vld, op_rdy, x_vld, x_rdy, y_vld, y_rdy, w_vld, w_rdy;
    logic [1:0]  op_code, op_sidx;
    logic signed [15:0] x_re, x_im, y_re, y_im, w_re, w_im;
    logic        res_vld, res_rdy;
    logic signed [15:0] r0_re, r0_im, r1_re, r1_im;

    fbf_alu uut (
        .clk(clk), .rst_n(rst_n),
        .op_vld_i(op_vld), .op_rdy_o(op_rdy), .op_code_i(op_code), .op_sidx_i(op_sidx),
        .x_vld_i(x_vld), .x_rdy_o(x_rdy), .x_re_i(x_re), .x_im_i(x_im),
        .y_vld_i(y_vld), .y_rdy_o(y_rdy), .y_re_i(y_re), .y_im_i(y_im),
        .w_vld_i(w_vld), .w_rdy_o(w_rdy), .w_re_i(w_re), .w_im_i(w_im),
        .res_vld_o(res_vld), .res_rdy_i(res_rdy),
        .r0_re_o(r0_re), .r0_im_o(r0_im), .r1_re_o(r1_re), .r1_im_o(r1_im)
    );

    int tests = 0, fails = 0, cycles = 0;
    bit hung = 0;
    int opq[$];
    logic [31:0] xq[$], yq[$], wq[$];
    int hist[4][3];
    bit m_vld = 0;
    int m_r0re, m_r0im, m_r1re, m_r1im, m_op;
    int last_r0re, last_r1re;
    bit pop_op, pop_x, pop_y, pop_w;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clip(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int rs(longint s);
        return clip((s + 16384) >>> 15);
    endfunction

    function automatic int hi(logic [31:0] d); return int'($signed(d[31:16])); endfunction
    function automatic int lo(logic [31:0] d); return int'($signed(d[15:0])); endfunction

    function automatic logic [31:0] rnd32();
        logic [31:0] v = $urandom;
        if ($urandom % 8 == 0) v[31:16] = 16'h8000;
        if ($urandom % 8 == 0) v[15:0]  = 16'h7FFF;
        return v;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R5 R6";
            1: return "R2 R3";
            2: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic push(int op, int sidx, logic [31:0] xd, logic [31:0] yd, logic [31:0] wd);
        opq.push_back(op * 4 + sidx);
        if (op != 3) begin xq.push_back(xd); wq.push_back(wd); end
        if (op == 0 || op == 2) yq.push_back(yd);
    endtask

    // Behavioural result for the operation at the queue heads
    task automatic model_fire();
        int op = opq[0] / 4, s = opq[0] % 4;
        logic [31:0] xd, yd, wd;
        longint tr, ti;
        xd = (op != 3) ? xq[0] : 32'd0;
        wd = (op != 3) ? wq[0] : 32'd0;
        yd = (op == 0 || op == 2) ? yq[0] : 32'd0;
        m_op = op;
        m_r0re = 0; m_r0im = 0; m_r1re = 0; m_r1im = 0;
        case (op)
            0: begin
                m_r0re = rs(longint'(hi(yd)) * hi(xd) + longint'(lo(yd)) * hist[s][0]
                          + longint'(hi(wd)) * hist[s][1] + longint'(lo(wd)) * hist[s][2]);
                hist[s][2] = hist[s][1];
                hist[s][1] = hist[s][0];
                hist[s][0] = hi(xd);
            end
            1: begin
                m_r0re = rs(longint'(hi(xd)) * hi(wd) - longint'(lo(xd)) * lo(wd));
                m_r0im = rs(longint'(hi(xd)) * lo(wd) + longint'(lo(xd)) * hi(wd));
            end
            2: begin
                tr = rs(longint'(hi(yd)) * hi(wd) - longint'(lo(yd)) * lo(wd));
                ti = rs(longint'(hi(yd)) * lo(wd) + longint'(lo(yd)) * hi(wd));
                m_r0re = clip(hi(xd) + tr);
                m_r0im = clip(lo(xd) + ti);
                m_r1re = clip(hi(xd) - tr);
                m_r1im = clip(lo(xd) - ti);
            end
            default: ;
        endcase
    endtask

    task automatic run_phase(int vprob, int rprob);
        bit done = 0;
        bit f, nx, ny, nw;
        int op;
        while (!done && !hung) begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                hung = 1;
                chk(0, "R10", "watchdog expired", cycles, 150000);
                break;
            end
            // results registered at the previous edge
            chk(res_vld == m_vld, m_vld ? "R10" : "R9 R10", "result valid", res_vld, m_vld);
            if (m_vld && res_vld) begin
                chk(r0_re == m_r0re, req_of(m_op), "r0_re", r0_re, m_r0re);
                chk(r0_im == m_r0im, req_of(m_op), "r0_im", r0_im, m_r0im);
                chk(r1_re == m_r1re, req_of(m_op), "r1_re", r1_re, m_r1re);
                chk(r1_im == m_r1im, req_of(m_op), "r1_im", r1_im, m_r1im);
                last_r0re = r0_re;
                last_r1re = r1_re;
            end
            if (pop_op) begin void'(opq.pop_front()); op_vld = 0; end
            if (pop_x) begin void'(xq.pop_front()); x_vld = 0; end
            if (pop_y) begin void'(yq.pop_front()); y_vld = 0; end
            if (pop_w) begin void'(wq.pop_front()); w_vld = 0; end
            pop_op = 0; pop_x = 0; pop_y = 0; pop_w = 0;
            if (!op_vld && opq.size() > 0 && ($urandom % 100) < vprob) begin
                op_vld = 1; op_code = 2'(opq[0] / 4); op_sidx = 2'(opq[0] % 4);
            end
            if (!x_vld && xq.size() > 0 && ($urandom % 100) < vprob) begin
                x_vld = 1; x_re = xq[0][31:16]; x_im = xq[0][15:0];
            end
            if (!y_vld && yq.size() > 0 && ($urandom % 100) < vprob) begin
                y_vld = 1; y_re = yq[0][31:16]; y_im = yq[0][15:0];
            end
            if (!w_vld && wq.size() > 0 && ($urandom % 100) < vprob) begin
                w_vld = 1; w_re = wq[0][31:16]; w_im = wq[0][15:0];
            end
            res_rdy = (($urandom % 100) < rprob);
            #1;
            op = op_vld ? opq[0] / 4 : 3;
            nx = op_vld && op != 3;
            ny = op_vld && (op == 0 || op == 2);
            nw = nx;
            f  = op_vld && (!nx || x_vld) && (!ny || y_vld) && (!nw || w_vld) && res_rdy;
            chk({op_rdy, x_rdy, y_rdy, w_rdy} == {f, f && nx, f && ny, f && nw},
                res_rdy ? "R7 R8" : "R9", "ready vector",
                int'({op_rdy, x_rdy, y_rdy, w_rdy}), int'({f, f && nx, f && ny, f && nw}));
            if (f) begin
                model_fire();
                m_vld = 1;
                pop_op = 1; pop_x = nx; pop_y = ny; pop_w = nw;
            end else if (res_rdy) begin
                m_vld = 0;
            end
            done = (opq.size() == 0 || (f && opq.size() == 1)) && !m_vld && !f
                   && xq.size() == 0 && yq.size() == 0 && wq.size() == 0;
            if (opq.size() == 0 && xq.size() == 0 && yq.size() == 0 && wq.size() == 0
                && !m_vld) done = 1;
        end
    endtask

    initial begin
        op_vld = 0; x_vld = 0; y_vld = 0; w_vld = 0; res_rdy = 0;
        op_code = 0; op_sidx = 0;
        x_re = 0; x_im = 0; y_re = 0; y_im = 0; w_re = 0; w_im = 0;
        pop_op = 0; pop_x = 0; pop_y = 0; pop_w = 0;
        for (int i = 0; i < 4; i++) for (int k = 0; k < 3; k++) hist[i][k] = 0;
        repeat (4) @(negedge clk);
        chk(res_vld == 1'b0, "R1", "valid in reset", res_vld, 0);
        rst_n = 1'b1;

        // Directed: one of each kind, R1 first FIR sees zero history
        push(0, 0, {16'h4000, 16'h0}, {16'h4000, 16'h1234}, {16'h7FFF, 16'h8000});
        push(1, 0, {16'h4000, 16'hC000}, 32'd0, {16'h2000, 16'h6000});
        push(2, 0, {16'h1000, 16'hF000}, {16'h3000, 16'h0800}, {16'h5A82, 16'hA57E});
        push(3, 0, 32'd0, 32'd0, 32'd0);
        push(0, 0, {16'h2000, 16'h0}, {16'h4000, 16'h4000}, {16'h4000, 16'h4000});
        run_phase(100, 100);

        // R6: interleaved histories on all four indices
        for (int n = 0; n < 24; n++)
            push(0, n % 4, rnd32(), rnd32(), rnd32());
        run_phase(100, 100);

        // Mixed traffic with operand gaps and a busy consumer (R9)
        for (int n = 0; n < 400; n++)
            push(int'($urandom % 4), int'($urandom % 4), rnd32(), rnd32(), rnd32());
        run_phase(60, 50);

        // R12: clipping corners
        push(1, 0, {16'h8000, 16'h0000}, 32'd0, {16'h8000, 16'h0000});
        run_phase(100, 100);
        chk(last_r0re == 32767, "R12", "(-1)*(-1) real", last_r0re, 32767);
        push(2, 0, {16'h7FFF, 16'h0000}, {16'h7FFF, 16'h0000}, {16'h7FFF, 16'h0000});
        run_phase(100, 100);
        chk(last_r0re == 32767, "R12", "butterfly sum real", last_r0re, 32767);
        chk(last_r1re == 1, "R12", "butterfly diff real", last_r1re, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule